// File: doc/BRIEF.md
# Variable-Width Coefficient Byte Packer

This block turns a stream of already-compressed polynomial coefficients into a little-endian byte stream. It keeps only the low d bits of each coefficient and places them one after another, least significant bit first. Whole bytes are released from the bottom of a small bit buffer as soon as eight or more bits are pending. The width d can be 4, 5, 10 or 11 bits. A run has two sections. The first section is K polynomials packed at the first width. The second section is one more polynomial packed at the second width, and its byte addresses follow on directly from the first section.

The coefficient producer may have variable latency, so the packer waits as long as needed for each coefficient. Every polynomial has 256 coefficients and therefore yields exactly 32·d bytes. As a result, the buffer is empty whenever one polynomial ends and the next begins. A single-cycle done pulse marks the moment the last byte of the run has been taken by the consumer.

Top module: `coef_byte_packer`

## Requirements
- R1: While rst_ni is low, and right after it rises, busy_o, done_o, coef_ready_o and byte_valid_o are 0 and byte_addr_o is 0. This holds even when reset is applied in the middle of a run.
- R2: A start_i pulse while idle begins a run: busy_o rises and byte_addr_o starts at 0. A start_i pulse while busy_o is high is ignored, and the byte stream in progress continues unchanged.
- R3: Width codes map 0→4, 1→5, 2→10 and 3→11 bits. Polynomials 0 to kpoly_i−1 use du_sel_i, and the final polynomial (index kpoly_i) uses dv_sel_i.
- R4: Only the low d bits of coef_data_i enter the stream. Higher bits have no effect on any output byte.
- R5: The coefficients form one LSB-first bit stream, with coefficient n placed directly above coefficient n−1. Output byte j carries stream bits 8j to 8j+7, with stream bit 8j in byte bit 0.
- R6: byte_valid_o is high exactly when at least 8 packed bits are pending. Each accepted byte (byte_valid_o and byte_ready_i both high) advances byte_addr_o by one, and addresses run unbroken from the first section into the second.
- R7: coef_ready_o is low while byte_valid_o is high, while idle, and once all 256·(kpoly_i+1) coefficients of the run have been accepted.
- R8: A run produces exactly 32·(kpoly_i·du + dv) bytes. No bits are pending when the first coefficient of any polynomial is accepted.
- R9: done_o is high for exactly one cycle: the cycle after the final byte is accepted. busy_o is low from that cycle on.
- R10: Gaps in coef_valid_i of any length stall the packer without losing or duplicating any coefficient.
- R11: While byte_valid_o is high and byte_ready_i is low, byte_valid_o, byte_data_o and byte_addr_o hold steady into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a run (used only when idle) |
| kpoly_i | input | KMAX_W | Number of polynomials in the first section |
| du_sel_i | input | 2 | Width code for the first section |
| dv_sel_i | input | 2 | Width code for the final polynomial |
| coef_valid_i | input | 1 | Coefficient offered |
| coef_data_i | input | 12 | Coefficient value (only the low d bits are used) |
| coef_ready_o | output | 1 | Coefficient can be taken this cycle |
| byte_valid_o | output | 1 | Packed byte available |
| byte_data_o | output | 8 | Packed byte |
| byte_addr_o | output | ADDR_W | Running byte address within the run |
| byte_ready_i | input | 1 | Consumer takes the byte |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse after the final byte |

## Verification
The bench uses coefficients with bits set above the field width. A packer that fails to mask them corrupts neighbouring fields, and the byte comparison catches this. Runs mix 10- and 11-bit fields with 4- and 5-bit fields, including a run with no first section. A design that keeps the wrong width after a section switch, or that restarts addresses at the section boundary, produces misplaced bytes. Heavy backpressure and sparse producer valid test whether bytes hold still while stalled and whether coefficients are dropped or doubled. A stray start in mid-run, a mid-run reset and an idle-time valid probe check for state that should not react. A late or repeated done pulse is caught by cycle-exact sampling.

// File: rtl/pk_pkg.sv
package pk_pkg;
  localparam int unsigned COEF_W = 12;
  localparam int unsigned DVAL_W = 4;

  typedef logic [1:0]        wsel_t;
  typedef logic [DVAL_W-1:0] dval_t;

  function automatic dval_t width_of(wsel_t s);
    case (s)
      2'd0:    return dval_t'(4);
      2'd1:    return dval_t'(5);
      2'd2:    return dval_t'(10);
      default: return dval_t'(11);
    endcase
  endfunction
endpackage

// File: rtl/pk_width_sel.sv
module pk_width_sel
  import pk_pkg::*;
#(
  parameter int unsigned CW = COEF_W
) (
  input  wsel_t          sel_i,
  output dval_t          d_o,
  output logic [CW-1:0]  mask_o
);
  assign d_o = width_of(sel_i);

  for (genvar i = 0; i < CW; i++) begin : g_mask
    assign mask_o[i] = (32'(d_o) > i);
  end
endmodule

// File: rtl/pk_bit_buffer.sv
module pk_bit_buffer #(
  parameter int unsigned CW     = 12,
  parameter int unsigned BUF_W  = 25,
  parameter int unsigned FILL_W = 6,
  parameter int unsigned DV_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              append_i,
  input  logic [CW-1:0]     coef_i,
  input  logic [CW-1:0]     mask_i,
  input  logic [DV_W-1:0]   d_i,
  input  logic              drain_i,
  output logic [7:0]        byte_o,
  output logic [FILL_W-1:0] fill_o
);
  logic [BUF_W-1:0]  bits_q;
  logic [FILL_W-1:0] fill_q;
  logic [BUF_W-1:0]  ins;

  // masked field placed at current fill position
  assign ins = BUF_W'(coef_i & mask_i) << fill_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bits_q <= '0;
      fill_q <= '0;
    end else if (clear_i) begin
      bits_q <= '0;
      fill_q <= '0;
    end else if (append_i) begin
      bits_q <= bits_q | ins;
      fill_q <= fill_q + FILL_W'(d_i);
    end else if (drain_i) begin
      bits_q <= bits_q >> 8;
      fill_q <= fill_q - FILL_W'(8);
    end
  end

  assign byte_o = bits_q[7:0];
  assign fill_o = fill_q;

  assert_append_room_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    append_i |-> fill_q < FILL_W'(8));
  assert_drain_full_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drain_i |-> fill_q >= FILL_W'(8));
  assert_one_op_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(append_i && drain_i));
  assert_no_overflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(fill_q) <= BUF_W);
  assert_clean_top_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bits_q >> fill_q) == '0);
endmodule

// File: rtl/pk_seq.sv
module pk_seq
  import pk_pkg::*;
#(
  parameter int unsigned NCOEF  = 256,
  parameter int unsigned POLY_W = 3,
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned FILL_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [POLY_W-1:0] kpoly_i,
  input  wsel_t             du_sel_i,
  input  wsel_t             dv_sel_i,
  input  logic              accept_i,
  input  logic              drain_i,
  input  logic [FILL_W-1:0] fill_i,
  output logic              busy_o,
  output logic              clear_o,
  output logic              all_in_o,
  output wsel_t             wsel_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              done_o
);
  localparam int unsigned CNT_W = $clog2(NCOEF);

  logic              busy_q, done_q, all_in_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [POLY_W-1:0] poly_q, kpoly_q;
  wsel_t             du_q, dv_q;
  logic [ADDR_W-1:0] addr_q;
  logic start_go, last_coef, last_poly, final_byte;

  assign start_go   = start_i && !busy_q;
  assign last_coef  = (cnt_q == CNT_W'(NCOEF - 1));
  assign last_poly  = (poly_q == kpoly_q);
  assign final_byte = drain_i && all_in_q && (fill_i == FILL_W'(8));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      all_in_q <= 1'b0;
      cnt_q    <= '0;
      poly_q   <= '0;
      kpoly_q  <= '0;
      du_q     <= '0;
      dv_q     <= '0;
      addr_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_go) begin
        busy_q   <= 1'b1;
        all_in_q <= 1'b0;
        cnt_q    <= '0;
        poly_q   <= '0;
        kpoly_q  <= kpoly_i;
        du_q     <= du_sel_i;
        dv_q     <= dv_sel_i;
        addr_q   <= '0;
      end else begin
        if (accept_i) begin
          if (last_coef) begin
            cnt_q <= '0;
            if (last_poly) all_in_q <= 1'b1;
            else           poly_q   <= poly_q + POLY_W'(1);
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        if (drain_i) begin
          addr_q <= addr_q + ADDR_W'(1);
          if (final_byte) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end
    end
  end

  assign busy_o   = busy_q;
  assign clear_o  = start_go;
  assign all_in_o = all_in_q;
  assign wsel_o   = last_poly ? dv_q : du_q;
  assign addr_o   = addr_q;
  assign done_o   = done_q;

  assert_boundary_empty_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_i && cnt_q == '0) |-> fill_i == '0);
  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  assert_done_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_q);
  assert_no_late_accept_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    all_in_q |-> !accept_i);
endmodule

// File: rtl/coef_byte_packer.sv
module coef_byte_packer
  import pk_pkg::*;
#(
  parameter int unsigned NCOEF  = 256,
  parameter int unsigned KMAX_W = 3,
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned BUF_W  = 25
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [KMAX_W-1:0] kpoly_i,
  input  logic [1:0]        du_sel_i,
  input  logic [1:0]        dv_sel_i,
  input  logic              coef_valid_i,
  input  logic [11:0]       coef_data_i,
  output logic              coef_ready_o,
  output logic              byte_valid_o,
  output logic [7:0]        byte_data_o,
  output logic [ADDR_W-1:0] byte_addr_o,
  input  logic              byte_ready_i,
  output logic              busy_o,
  output logic              done_o
);
  localparam int unsigned FILL_W = $clog2(BUF_W + 1) + 1;

  logic              busy, clear, all_in, accept, drain;
  wsel_t             wsel;
  dval_t             dval;
  logic [COEF_W-1:0] mask;
  logic [FILL_W-1:0] fill;

  assign coef_ready_o = busy && !all_in && (fill < FILL_W'(8));
  assign byte_valid_o = busy && (fill >= FILL_W'(8));
  assign accept       = coef_valid_i && coef_ready_o;
  assign drain        = byte_valid_o && byte_ready_i;
  assign busy_o       = busy;

  pk_seq #(
    .NCOEF (NCOEF),
    .POLY_W(KMAX_W),
    .ADDR_W(ADDR_W),
    .FILL_W(FILL_W)
  ) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .kpoly_i (kpoly_i),
    .du_sel_i(du_sel_i),
    .dv_sel_i(dv_sel_i),
    .accept_i(accept),
    .drain_i (drain),
    .fill_i  (fill),
    .busy_o  (busy),
    .clear_o (clear),
    .all_in_o(all_in),
    .wsel_o  (wsel),
    .addr_o  (byte_addr_o),
    .done_o  (done_o)
  );

  pk_width_sel #(.CW(COEF_W)) u_wsel (
    .sel_i (wsel),
    .d_o   (dval),
    .mask_o(mask)
  );

  pk_bit_buffer #(
    .CW    (COEF_W),
    .BUF_W (BUF_W),
    .FILL_W(FILL_W),
    .DV_W  (DVAL_W)
  ) u_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear),
    .append_i(accept),
    .coef_i  (coef_data_i),
    .mask_i  (mask),
    .d_i     (dval),
    .drain_i (drain),
    .byte_o  (byte_data_o),
    .fill_o  (fill)
  );

  assert_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_o && !byte_ready_i) |=>
      (byte_valid_o && $stable(byte_data_o) && $stable(byte_addr_o)));
  assert_done_after_byte_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(drain));
endmodule

// File: tb/coef_byte_packer_test.sv
module coef_byte_packer_test;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [2:0] kpoly_i = '0;
  logic [1:0] du_sel_i = '0, dv_sel_i = '0;
  logic coef_valid_i = 1'b0;
  logic [11:0] coef_data_i = '0;
  logic coef_ready_o, byte_valid_o, byte_ready_i, busy_o, done_o;
  logic [7:0] byte_data_o;
  logic [10:0] byte_addr_o;

  int errors = 0;
  int checks = 0;
  logic [15:0] lf = 16'hACE1;

  always #2 clk_i = ~clk_i;

  coef_byte_packer uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .kpoly_i(kpoly_i),
    .du_sel_i(du_sel_i), .dv_sel_i(dv_sel_i), .coef_valid_i(coef_valid_i),
    .coef_data_i(coef_data_i), .coef_ready_o(coef_ready_o),
    .byte_valid_o(byte_valid_o), .byte_data_o(byte_data_o),
    .byte_addr_o(byte_addr_o), .byte_ready_i(byte_ready_i),
    .busy_o(busy_o), .done_o(done_o)
  );

  // fields: [15:13] kpoly [12:11] du [10:9] dv [8:7] pattern [6:5] backpressure [4:3] gaps [2] stray start
  localparam logic [15:0] VEC [5] = '{
    {3'd2, 2'd2, 2'd0, 2'd0, 2'd0, 2'd0, 3'd0},
    {3'd3, 2'd3, 2'd1, 2'd1, 2'd1, 2'd1, 3'd0},
    {3'd4, 2'd2, 2'd0, 2'd0, 2'd1, 2'd1, 3'd4},
    {3'd0, 2'd0, 2'd3, 2'd2, 2'd2, 2'd0, 3'd0},
    {3'd1, 2'd1, 2'd2, 2'd0, 2'd2, 2'd2, 3'd4}
  };

  function automatic int wid(logic [1:0] c);
    return (c == 2'd0) ? 4 : (c == 2'd1) ? 5 : (c == 2'd2) ? 10 : 11;
  endfunction

  function automatic logic [11:0] gen(int n, logic [1:0] pat);
    case (pat)
      2'd1:    return 12'hFFF;
      2'd2:    return (n % 2 == 1) ? 12'hAAA : 12'h555;
      default: return 12'((n * 1103 + 977) ^ (n >> 3));
    endcase
  endfunction

  task automatic step_lf();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_vec(input logic [15:0] v);
    int k = int'(v[15:13]);
    logic [1:0] du = v[12:11], dv = v[10:9], pat = v[8:7], bp = v[6:5], gp = v[4:3];
    bit stray = v[2];
    int total_c = 256 * (k + 1);
    int exp_bytes = 32 * (k * wid(du) + wid(dv));
    int n = 0, bytes = 0, cyc = 0, mcnt = 0;
    int bad_byte = 0, bad_hold = 0, bad_bound = 0, bad_done = 0, bad_excl = 0;
    int fa = 0, fe = 0;
    bit cv = 0, done_seen = 0, expect_done = 0, hold_pend = 0;
    logic [11:0] cd = '0;
    logic [63:0] mbits = '0;
    logic [7:0] hd = '0;
    logic [10:0] ha = '0;
    @(negedge clk_i);
    start_i = 1'b1; kpoly_i = 3'(k); du_sel_i = du; dv_sel_i = dv;
    @(negedge clk_i);
    start_i = 1'b0;
    #1;
    chk(busy_o == 1'b1 && byte_addr_o == '0, "R2 start", int'(busy_o), 1);
    while (!done_seen && cyc < 40000) begin
      cyc++;
      step_lf();
      start_i = stray && (cyc == 300);
      if (start_i) begin kpoly_i = 3'd7; du_sel_i = 2'd0; dv_sel_i = 2'd0; end
      if (!cv && n < total_c) begin
        cv = (gp == 2'd0) || (gp == 2'd1 && lf[0]) || (gp == 2'd2 && cyc % 4 == 0);
        cd = gen(n, pat);
      end
      coef_valid_i = cv;
      coef_data_i = cd;
      byte_ready_i = (bp == 2'd0) || (bp == 2'd1 && lf[3]) || (bp == 2'd2 && cyc % 3 == 0);
      #1;
      if (expect_done) begin
        if (!done_o || busy_o) bad_done++;
        done_seen = 1;
      end else if (done_o) bad_done++;
      if (done_seen) break;
      if (coef_ready_o && byte_valid_o) bad_excl++;
      if (byte_valid_o != (mcnt >= 8)) bad_byte++;
      if (hold_pend) begin
        if (!byte_valid_o || byte_data_o != hd || byte_addr_o != ha) bad_hold++;
        hold_pend = 0;
      end
      if (cv && coef_ready_o) begin
        int d = wid(((n / 256) < k) ? du : dv);
        if (n % 256 == 0 && (mcnt != 0 || bytes != 32 * (n / 256) * wid(du))) bad_bound++;
        mbits = mbits | (64'(cd & 12'((1 << d) - 1)) << mcnt);
        mcnt += d;
        n++;
        cv = 0;
      end
      if (byte_valid_o && byte_ready_i) begin
        if (byte_data_o != mbits[7:0] || byte_addr_o != 11'(bytes)) begin
          if (bad_byte == 0) begin fa = int'(byte_data_o); fe = int'(mbits[7:0]); end
          bad_byte++;
        end
        mbits = mbits >> 8;
        mcnt -= 8;
        bytes++;
        if (bytes == exp_bytes) expect_done = 1;
      end else if (byte_valid_o) begin
        hold_pend = 1; hd = byte_data_o; ha = byte_addr_o;
      end
      @(negedge clk_i);
    end
    coef_valid_i = 1'b0;
    byte_ready_i = 1'b0;
    start_i = 1'b0;
    chk(bad_byte == 0, "R2 R3 R4 R5 R6 byte stream", fa, fe);
    chk(bytes == exp_bytes, "R8 byte count", bytes, exp_bytes);
    chk(bad_bound == 0, "R8 polynomial boundary", bad_bound, 0);
    chk(done_seen && bad_done == 0, "R9 done pulse", bad_done, 0);
    chk(bad_excl == 0, "R7 no accept while byte pending", bad_excl, 0);
    chk(bad_hold == 0, "R11 hold under backpressure", bad_hold, 0);
    chk(n == total_c, "R10 all coefficients taken", n, total_c);
    @(negedge clk_i);
    #1;
    chk(!done_o && !busy_o && !coef_ready_o, "R9 idle after done", int'(done_o), 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin : main
    byte_ready_i = 1'b0;
    repeat (3) @(negedge clk_i);
    #1;
    chk(!busy_o && !done_o, "R1 in reset busy/done", int'(busy_o), 0);
    chk(!coef_ready_o && !byte_valid_o, "R1 in reset handshakes", int'(coef_ready_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    #1;
    chk(!busy_o && !coef_ready_o && !byte_valid_o, "R1 after reset", int'(busy_o), 0);
    chk(byte_addr_o == '0, "R1 address", int'(byte_addr_o), 0);

    // idle probe: offered coefficient must not be taken
    coef_valid_i = 1'b1;
    coef_data_i = 12'hFFF;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      #1;
      chk(!coef_ready_o && !byte_valid_o, "R7 idle refuses coefficient", int'(coef_ready_o), 0);
    end
    coef_valid_i = 1'b0;

    // mid-run reset
    @(negedge clk_i);
    start_i = 1'b1; kpoly_i = 3'd1; du_sel_i = 2'd2; dv_sel_i = 2'd0;
    @(negedge clk_i);
    start_i = 1'b0;
    coef_valid_i = 1'b1;
    byte_ready_i = 1'b1;
    for (int i = 0; i < 100; i++) begin
      coef_data_i = 12'(i * 37);
      @(negedge clk_i);
    end
    #1;
    chk(byte_addr_o != '0, "R6 address advanced before reset", int'(byte_addr_o), 1);
    rst_ni = 1'b0;
    #1;
    chk(!busy_o && !byte_valid_o && !coef_ready_o && byte_addr_o == '0,
        "R1 mid-run reset", int'(byte_addr_o), 0);
    coef_valid_i = 1'b0;
    byte_ready_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;

    for (int e = 0; e < 5; e++) run_vec(VEC[e]);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule